// File: doc/BRIEF.md
# Priority Memory Select Decoder

This block turns raw region-match hits into chip selects for an 8-bit microcontroller that keeps program space and data space apart. Five region hits come in: SRAM, I/O, peripheral I/O, boot flash and main flash. Two access strobes come in with them: `psen`, which is high during an instruction fetch, and `rd`, which is high during a data read. The block asserts at most one select per access.

A mapping register, writable at run time, decides which strobe may open each memory. Software can therefore place a flash array in code space, in data space or in both, and can swap the two flash arrays later without a reset. When regions overlap, a fixed three-level order picks the winner: the SRAM/I/O group first, then boot flash, then main flash. If the winner's strobe is not allowed by the register, the access selects nothing.

The selects are combinational from the hits, the strobes and the registered mapping value. A write to the register is visible from the next cycle.

Top module: `memsel_decoder`

## Requirements
- R1: After reset, `map_rdata` equals the parameter `RST_MAP` with bits 6 and 5 cleared. The default gives 8'h12: main flash readable by `rd`, boot flash readable by `psen`.
- R2: When `map_we` is high at a rising edge, `map_rdata` shows `map_wdata & 8'h9F` from the next cycle on. Bits 6 and 5 always read 0, and a write to them has no effect.
- R3: Overlapping hits resolve in this order: SRAM, then I/O, then peripheral I/O (these three form level 1), then boot flash, then main flash.
- R4: At most one of the five selects is high in any cycle.
- R5: An SRAM hit selects SRAM whenever `rd` is high. With `psen` alone, it selects SRAM only if map bit 0 is 1.
- R6: A boot-flash winner is selected by `psen` when map bit 1 is 1, or by `rd` when map bit 3 is 1.
- R7: A main-flash winner is selected by `psen` when map bit 2 is 1, or by `rd` when map bit 4 is 1.
- R8: The I/O and peripheral I/O regions answer only to `rd`. A peripheral I/O hit counts only while map bit 7 is 1. While bit 7 is 0, that hit is ignored and lower levels may win.
- R9: If the winning region's strobe is not allowed, no select is asserted. The hit does not fall through to a lower-priority memory.
- R10: With both `psen` and `rd` low, every select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_sram | input | 1 | Address falls in the SRAM region |
| hit_io | input | 1 | Address falls in the I/O region |
| hit_pio | input | 1 | Address falls in the peripheral I/O region |
| hit_boot | input | 1 | Address falls in the boot flash region |
| hit_main | input | 1 | Address falls in the main flash region |
| psen | input | 1 | Program fetch strobe, high active |
| rd | input | 1 | Data read strobe, high active |
| map_we | input | 1 | Mapping register write enable |
| map_wdata | input | 8 | Mapping register write value |
| map_rdata | output | 8 | Mapping register contents |
| cs_sram | output | 1 | SRAM select |
| cs_io | output | 1 | I/O select |
| cs_pio | output | 1 | Peripheral I/O select |
| cs_boot | output | 1 | Boot flash select |
| cs_main | output | 1 | Main flash select |

## Verification
The selects settle in the same cycle the hits and strobes change, with no register in between. The bench drives these inputs on the falling edge and compares the selects one time unit later, before the next rising edge. A mapping write needs one rising edge. The bench samples `map_rdata` only after that edge and switches its own model of the map at that same edge, so every select check after a write uses the new value. The bench computes expected selects with its own priority function over random hits, strobes and map values.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    localparam int MAP_W = 8;
    localparam logic [MAP_W-1:0] MAP_USED = 8'h9F;

    typedef struct packed {
        logic       pio_en;     // bit 7
        logic [1:0] spare;      // bits 6:5
        logic       main_data;  // bit 4
        logic       boot_data;  // bit 3
        logic       main_code;  // bit 2
        logic       boot_code;  // bit 1
        logic       sram_code;  // bit 0
    } map_t;

    typedef struct packed {
        logic sram;
        logic io;
        logic pio;
        logic boot;
        logic main;
    } hits_t;

    typedef struct packed {
        logic sram;
        logic io;
        logic pio;
        logic boot;
        logic main;
    } cs_t;

    typedef enum logic [2:0] {
        WIN_NONE, WIN_SRAM, WIN_IO, WIN_PIO, WIN_BOOT, WIN_MAIN
    } win_e;

    function automatic map_t map_clean(input logic [MAP_W-1:0] raw);
        return map_t'(raw & MAP_USED);
    endfunction

    function automatic cs_t win_to_cs(input win_e w);
        cs_t c;
        c = '0;
        case (w)
            WIN_SRAM: c.sram = 1'b1;
            WIN_IO:   c.io   = 1'b1;
            WIN_PIO:  c.pio  = 1'b1;
            WIN_BOOT: c.boot = 1'b1;
            WIN_MAIN: c.main = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/memsel_map_reg.sv
module memsel_map_reg
    import memsel_pkg::*;
#(
    parameter logic [MAP_W-1:0] RST_MAP = 8'h12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [MAP_W-1:0] wr_data,
    output map_t             map_q
);

    always_ff @(posedge clk) begin
        if (rst)        map_q <= map_clean(RST_MAP);
        else if (wr_en) map_q <= map_clean(wr_data);
    end

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        map_q.spare == 2'b00);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (map_q == ($past(wr_data) & MAP_USED)));

endmodule

// File: rtl/memsel_prio.sv
module memsel_prio
    import memsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hits_t hits,
    input  logic  pio_en,
    output win_e  win
);

    always_comb begin
        if (hits.sram)                 win = WIN_SRAM;
        else if (hits.io)              win = WIN_IO;
        else if (hits.pio && pio_en)   win = WIN_PIO;
        else if (hits.boot)            win = WIN_BOOT;
        else if (hits.main)            win = WIN_MAIN;
        else                           win = WIN_NONE;
    end

    // R3
    boot_blocks_main_chk: assert property (@(posedge clk) disable iff (rst)
        hits.boot |-> (win != WIN_MAIN));

    // R8
    pio_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (win == WIN_PIO) |-> pio_en);

endmodule

// File: rtl/memsel_gate.sv
module memsel_gate
    import memsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  win_e win,
    input  logic fetch,
    input  logic read,
    input  map_t map,
    output cs_t  cs
);

    logic allowed;

    always_comb begin
        case (win)
            WIN_SRAM: allowed = read | (fetch & map.sram_code);
            WIN_IO,
            WIN_PIO:  allowed = read;
            WIN_BOOT: allowed = (read & map.boot_data) | (fetch & map.boot_code);
            WIN_MAIN: allowed = (read & map.main_data) | (fetch & map.main_code);
            default:  allowed = 1'b0;
        endcase
        cs = allowed ? win_to_cs(win) : '0;
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch && !read) |-> (cs == '0));

    // R9
    denied_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (win == WIN_BOOT && !read && !map.boot_code) |-> (cs == '0));

    // R2
    spare_unused_chk: assert property (@(posedge clk) disable iff (rst)
        map.spare == 2'b00);

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter logic [MAP_W-1:0] RST_MAP = 8'h12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_sram,
    input  logic             hit_io,
    input  logic             hit_pio,
    input  logic             hit_boot,
    input  logic             hit_main,
    input  logic             psen,
    input  logic             rd,
    input  logic             map_we,
    input  logic [MAP_W-1:0] map_wdata,
    output logic [MAP_W-1:0] map_rdata,
    output logic             cs_sram,
    output logic             cs_io,
    output logic             cs_pio,
    output logic             cs_boot,
    output logic             cs_main
);

    map_t  map_q;
    hits_t hits;
    win_e  win;
    cs_t   cs;

    assign hits = '{sram: hit_sram, io: hit_io, pio: hit_pio,
                    boot: hit_boot, main: hit_main};

    memsel_map_reg #(.RST_MAP(RST_MAP)) u_map (
        .clk(clk), .rst(rst), .wr_en(map_we), .wr_data(map_wdata), .map_q(map_q)
    );

    memsel_prio u_prio (
        .clk(clk), .rst(rst), .hits(hits), .pio_en(map_q.pio_en), .win(win)
    );

    memsel_gate u_gate (
        .clk(clk), .rst(rst), .win(win), .fetch(psen), .read(rd),
        .map(map_q), .cs(cs)
    );

    assign map_rdata = map_q;
    assign cs_sram   = cs.sram;
    assign cs_io     = cs.io;
    assign cs_pio    = cs.pio;
    assign cs_boot   = cs.boot;
    assign cs_main   = cs.main;

    // R4
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_sram, cs_io, cs_pio, cs_boot, cs_main}));

    // R3
    main_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        cs_main |-> (!hit_sram && !hit_io && !hit_boot));

    // R8
    pio_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        cs_pio |-> (map_rdata[7] && rd));

    // R5
    sram_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_sram && !rd) |-> map_rdata[0]);

endmodule

// File: tb/memsel_decoder_bench.sv
`timescale 1ns/100ps
module memsel_decoder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs = 0, hi = 0, hp = 0, hb = 0, hm = 0, ps = 0, rdd = 0, we = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic c_sram, c_io, c_pio, c_boot, c_main;
    logic [7:0] emap;
    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    memsel_decoder u_memsel_decoder (
        .clk(clk), .rst(rst), .hit_sram(hs), .hit_io(hi), .hit_pio(hp),
        .hit_boot(hb), .hit_main(hm), .psen(ps), .rd(rdd), .map_we(we),
        .map_wdata(wdata), .map_rdata(rdata), .cs_sram(c_sram), .cs_io(c_io),
        .cs_pio(c_pio), .cs_boot(c_boot), .cs_main(c_main)
    );

    // expected select vector {sram, io, pio, boot, main}
    function automatic logic [4:0] model(input logic [4:0] h, input logic f,
                                         input logic r, input logic [7:0] m);
        if (h[4])                 return (r | (f & m[0])) ? 5'b10000 : 5'b0;
        if (h[3])                 return r ? 5'b01000 : 5'b0;
        if (h[2] && m[7])         return r ? 5'b00100 : 5'b0;
        if (h[1])                 return ((r & m[3]) | (f & m[1])) ? 5'b00010 : 5'b0;
        if (h[0])                 return ((r & m[4]) | (f & m[2])) ? 5'b00001 : 5'b0;
        return 5'b0;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [4:0] h, input logic f, input logic r, input string req);
        @(negedge clk);
        {hs, hi, hp, hb, hm} = h;
        ps = f; rdd = r;
        #1;
        check(req, {3'b0, c_sram, c_io, c_pio, c_boot, c_main}, {3'b0, model(h, f, r, emap)});
        if (!$onehot0({c_sram, c_io, c_pio, c_boot, c_main})) begin
            errors++; checks++;
            $display("FAIL R4: selects %b expected one-hot-or-zero",
                     {c_sram, c_io, c_pio, c_boot, c_main});
        end
    endtask

    task automatic write_map(input logic [7:0] v);
        @(negedge clk);
        we = 1'b1; wdata = v;
        @(posedge clk);
        emap = v & 8'h9F;
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R2 write", rdata, v & 8'h9F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        emap = 8'h12;
        #1;
        check("R1 reset value", rdata, 8'h12);
        // R10: no strobe
        access(5'b11111, 0, 0, "R10");
        // R7 / R6 at reset map: main by rd, boot by psen
        access(5'b00001, 0, 1, "R7 main rd");
        access(5'b00001, 1, 0, "R7 main psen denied");
        access(5'b00010, 1, 0, "R6 boot psen");
        access(5'b00011, 0, 1, "R9 boot rd denied, no fall-through");
        // R5: SRAM by rd always; psen needs bit0
        access(5'b10011, 0, 1, "R3 R5 sram wins");
        access(5'b10000, 1, 0, "R5 sram psen denied");
        // R8: pio disabled falls through
        access(5'b00101, 0, 1, "R8 pio off");
        access(5'b01000, 1, 0, "R8 io psen");
        // R2: spare bits masked
        write_map(8'hFF);
        access(5'b00101, 0, 1, "R8 pio on");
        access(5'b10000, 1, 0, "R5 sram psen");
        access(5'b01100, 0, 1, "R3 io over pio");
        write_map(8'h60);
        access(5'b00011, 1, 1, "R9 all denied");
        // swap flashes: main code, boot data
        write_map(8'h0C);
        access(5'b00001, 1, 0, "R7 main psen swapped");
        access(5'b00010, 0, 1, "R6 boot rd swapped");
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) write_map(8'($urandom));
            else access(5'($urandom), 1'($urandom), 1'($urandom), "R3 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule